// File: doc/BRIEF.md
# GPIO Port with Routed Interrupts

This block is a general-purpose I/O port of up to 32 lines, controlled through a simple 32-bit register bus with one-cycle read latency. Software sets an output value and a per-line drive enable, and it reads back the sampled pin levels. Each input passes through a two-stage synchroniser. A per-line skip bit lets a line be sampled straight from the pin instead.

Every line can raise an interrupt. Two per-line bits choose the condition: a level bit pair picks level or edge, and a sense bit picks low/falling or high/rising. A per-line enable gates the condition. A routing table then steers each line to one of several interrupt wires, or to no wire. Each wire carries the registered OR of the enabled, active lines routed to it. Several lines may share a wire, and an edge event holds its wire high for exactly one clock.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the output, drive-enable, enable, sense, edge-select and skip registers read 0, and every routing word reads 0x80808080. All interrupt wires are low.
- R2: Word 0x04 (output value) drives `pin_out` and word 0x08 (drive enable) drives `pin_oe`, bit i for line i. Both take effect the cycle after the write and read back as written.
- R3: A read of word 0x00 returns the pin levels through the two-flop synchroniser. A pin change is first seen by a read issued two cycles after the change. Writes to 0x00 have no effect.
- R4: When bit i of the skip register (word 0x18) is 1, line i's read value and interrupt logic use the pin directly, with no synchroniser delay. The skip register reads back as written.
- R5: With sense 0 (word 0x10) and edge-select 0 (word 0x14), an enabled line is active for as long as its synchronised input is low.
- R6: With sense 1 and edge-select 0, an enabled line is active for as long as its synchronised input is high.
- R7: With sense 0 and edge-select 1, a falling edge of the synchronised input makes the line active for exactly one cycle. A rising edge does nothing.
- R8: With sense 1 and edge-select 1, a rising edge makes the line active for exactly one cycle.
- R9: A line whose bit in the enable register (word 0x0C) is 0 never contributes to any interrupt wire.
- R10: Line i's route is byte i%4 of word 0x20 + 4*(i/4). A byte with bit 7 set, or whose low seven bits are NIRQ or more, routes the line nowhere. Otherwise the low bits give the wire index.
- R11: An interrupt wire is the OR of all enabled, active lines routed to it, so lines sharing a wire keep it high while any one of them is active.
- R12: Interrupt wires are registered. A wire changes one clock after the line condition changes, which is three clocks after a synchronised pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | NLINES | Pin input levels |
| pin_out | output | NLINES | Output value for each pin |
| pin_oe | output | NLINES | Drive enable for each pin |
| irq_out | output | NIRQ | Routed interrupt wires |

## Verification
The condition logic is tried in all four sense/edge combinations on different lines. Each pin is toggled both ways, so level behaviour (the wire stays high) is told apart from edge behaviour (a one-cycle pulse), and the ignored edge direction is shown to do nothing. Two lines on one wire are switched in opposite directions in the same cycle, which separates an OR from a last-writer result. Routing bytes are tried with the none bit, with an out-of-range index and with a valid index, to tell the two no-route forms from a real route. A pin change issued in the same cycle as a read tells the skip path from the synchronised path.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned REG_AW = 8;

  // word indices (byte address / 4)
  localparam logic [5:0] W_DATA = 6'd0;
  localparam logic [5:0] W_OUT  = 6'd1;
  localparam logic [5:0] W_DIR  = 6'd2;
  localparam logic [5:0] W_MASK = 6'd3;
  localparam logic [5:0] W_POL  = 6'd4;
  localparam logic [5:0] W_EDGE = 6'd5;
  localparam logic [5:0] W_BYP  = 6'd6;
  localparam int unsigned W_ROUTE0 = 8;

  localparam logic [7:0] ROUTE_NONE = 8'h80;

  // condition of one line from its sense/edge bits and input events
  function automatic logic line_cond(logic sense, logic edg, logic cur,
                                     logic rise, logic fall);
    if (edg) return sense ? rise : fall;
    return sense ? cur : ~cur;
  endfunction

  // routing byte selects interrupt wire idx
  function automatic logic route_hit(logic [7:0] fld, logic [6:0] idx);
    return !fld[7] && (fld[6:0] == idx);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pin_in,
  input  logic [NLINES-1:0] byp_q,
  output logic [NLINES-1:0] cur,
  output logic [NLINES-1:0] rise_ev,
  output logic [NLINES-1:0] fall_ev
);

  logic [NLINES-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= cur;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_sel
    assign cur[i] = byp_q[i] ? pin_in[i] : sync_q[i];
  end

  assign rise_ev = cur & ~prev_q;
  assign fall_ev = ~cur & prev_q;

  // R8
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev & $past(rise_ev)) == '0);

  // R7
  fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev & $past(fall_ev)) == '0);

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NLINES-1:0]   data_in,
  output logic [NLINES-1:0]   out_q,
  output logic [NLINES-1:0]   dir_q,
  output logic [NLINES-1:0]   mask_q,
  output logic [NLINES-1:0]   pol_q,
  output logic [NLINES-1:0]   edge_q,
  output logic [NLINES-1:0]   byp_q,
  output logic [NLINES*8-1:0] route_q
);

  logic [5:0]        widx;
  logic              wr_en, rd_en;
  logic [NLINES-1:0] wdat;
  logic [7:0]        route_r [NLINES];
  logic [31:0]       rd_word;

  assign widx  = bus_addr[7:2];
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;
  assign wdat  = bus_wdata[NLINES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      byp_q  <= '0;
    end else if (wr_en) begin
      case (widx)
        W_OUT:   out_q  <= wdat;
        W_DIR:   dir_q  <= wdat;
        W_MASK:  mask_q <= wdat;
        W_POL:   pol_q  <= wdat;
        W_EDGE:  edge_q <= wdat;
        W_BYP:   byp_q  <= wdat;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLINES; l++) route_r[l] <= ROUTE_NONE;
    end else if (wr_en) begin
      for (int l = 0; l < NLINES; l++)
        if (widx == 6'(W_ROUTE0 + l / 4))
          route_r[l] <= bus_wdata[(l % 4) * 8 +: 8];
    end
  end

  for (genvar l = 0; l < NLINES; l++) begin : g_flat
    assign route_q[l*8 +: 8] = route_r[l];
  end

  always_comb begin
    rd_word = '0;
    case (widx)
      W_DATA:  rd_word = 32'(data_in);
      W_OUT:   rd_word = 32'(out_q);
      W_DIR:   rd_word = 32'(dir_q);
      W_MASK:  rd_word = 32'(mask_q);
      W_POL:   rd_word = 32'(pol_q);
      W_EDGE:  rd_word = 32'(edge_q);
      W_BYP:   rd_word = 32'(byp_q);
      default: begin
        for (int l = 0; l < NLINES; l++)
          if (widx == 6'(W_ROUTE0 + l / 4))
            rd_word[(l % 4) * 8 +: 8] = route_r[l];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_word;
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == W_DIR) |=> (dir_q == $past(wdat)));

  // R2
  out_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && widx == W_OUT) |=> (bus_rdata == 32'($past(out_q))));

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NLINES = 32,
  parameter int unsigned NIRQ   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NLINES-1:0]   cur,
  input  logic [NLINES-1:0]   rise_ev,
  input  logic [NLINES-1:0]   fall_ev,
  input  logic [NLINES-1:0]   mask_q,
  input  logic [NLINES-1:0]   pol_q,
  input  logic [NLINES-1:0]   edge_q,
  input  logic [NLINES*8-1:0] route_q,
  output logic [NIRQ-1:0]     irq_out
);

  logic [NLINES-1:0] line_act;
  logic [NIRQ-1:0]   hit;

  for (genvar l = 0; l < NLINES; l++) begin : g_cond
    assign line_act[l] = mask_q[l] &
      line_cond(pol_q[l], edge_q[l], cur[l], rise_ev[l], fall_ev[l]);
  end

  always_comb begin
    hit = '0;
    for (int k = 0; k < NIRQ; k++)
      for (int l = 0; l < NLINES; l++)
        if (line_act[l] && route_hit(route_q[l*8 +: 8], 7'(k)))
          hit[k] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= hit;
  end

  // R9
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> (irq_out == '0));

  // R11
  wire_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_act == '0) |=> (irq_out == '0));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NLINES = 32,
  parameter int unsigned NIRQ   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic [NIRQ-1:0]   irq_out
);

  logic [NLINES-1:0]   cur, rise_ev, fall_ev;
  logic [NLINES-1:0]   out_q, dir_q, mask_q, pol_q, edge_q, byp_q;
  logic [NLINES*8-1:0] route_q;

  gpio_regs #(.NLINES(NLINES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .data_in   (cur),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .pol_q     (pol_q),
    .edge_q    (edge_q),
    .byp_q     (byp_q),
    .route_q   (route_q)
  );

  gpio_in_sync #(.NLINES(NLINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .byp_q   (byp_q),
    .cur     (cur),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  gpio_irq_route #(.NLINES(NLINES), .NIRQ(NIRQ)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .cur     (cur),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .mask_q  (mask_q),
    .pol_q   (pol_q),
    .edge_q  (edge_q),
    .route_q (route_q),
    .irq_out (irq_out)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pins = '0;
  logic [31:0] pin_out, pin_oe;
  logic [3:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] exp;
  } item_t;
  item_t sb_q[$];
  item_t it;
  logic  rd_pend = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_port #(.NLINES(32), .NIRQ(4)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pins),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: a read sampled at a posedge is compared at the next negedge
  always @(posedge clk) rd_pend <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (sb_q.size() == 0) check("scoreboard empty", 32'd1, 32'd0);
      else begin
        it = sb_q.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, logic [31:0] exp, string tag);
    item_t n;
    n.tag = tag; n.exp = exp;
    sb_q.push_back(n);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic check_irq(string tag, logic [3:0] exp);
    check(tag, 32'(irq_out), 32'(exp));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd_reg(8'h04, 32'h0, "R1 out");
    rd_reg(8'h08, 32'h0, "R1 dir");
    rd_reg(8'h0C, 32'h0, "R1 enable");
    rd_reg(8'h10, 32'h0, "R1 sense");
    rd_reg(8'h14, 32'h0, "R1 edge");
    rd_reg(8'h18, 32'h0, "R1 skip");
    rd_reg(8'h20, 32'h80808080, "R1 route0");
    rd_reg(8'h3C, 32'h80808080, "R1 route7");
    check_irq("R1 irq", 4'h0);

    // R2 output and drive enable
    wr_reg(8'h04, 32'hA5A50F0F);
    wr_reg(8'h08, 32'hFFFF0000);
    check("R2 pin_out", pin_out, 32'hA5A50F0F);
    check("R2 pin_oe", pin_oe, 32'hFFFF0000);
    rd_reg(8'h04, 32'hA5A50F0F, "R2 out read");
    rd_reg(8'h08, 32'hFFFF0000, "R2 dir read");

    // R3 synchronised data, write ignored, latency
    pins = 32'h12345678;
    wr_reg(8'h00, 32'hFFFFFFFF);
    step(3);
    rd_reg(8'h00, 32'h12345678, "R3 data");
    pins = 32'hFFFFFFFF;
    rd_reg(8'h00, 32'h12345678, "R3 latency 1");
    rd_reg(8'h00, 32'h12345678, "R3 latency 2");
    rd_reg(8'h00, 32'hFFFFFFFF, "R3 latency 3");

    // R10 routing table
    wr_reg(8'h20, 32'h80810100);
    wr_reg(8'h24, 32'h80020280);
    wr_reg(8'h28, 32'h80800780);
    rd_reg(8'h20, 32'h80810100, "R10 route0 read");
    rd_reg(8'h28, 32'h80800780, "R10 route2 read");

    // R5 / R12 level low on line 0 -> wire 0
    wr_reg(8'h0C, 32'h1);
    step(1);
    check_irq("R5 idle high", 4'h0);
    pins[0] = 1'b0;
    step(2);
    check_irq("R12 not yet", 4'h0);
    step(1);
    check_irq("R5 low active", 4'h1);
    step(2);
    check_irq("R5 level held", 4'h1);
    pins[0] = 1'b1;
    step(3);
    check_irq("R5 released", 4'h0);

    // R9 enable gating
    pins[0] = 1'b0;
    wr_reg(8'h0C, 32'h0);
    step(3);
    check_irq("R9 masked", 4'h0);
    wr_reg(8'h0C, 32'h1);
    step(1);
    check_irq("R9 unmasked", 4'h1);
    wr_reg(8'h0C, 32'h0);
    step(1);
    check_irq("R9 masked again", 4'h0);
    pins[0] = 1'b1;

    // R6 level high on line 1 -> wire 1
    wr_reg(8'h10, 32'h2);
    wr_reg(8'h0C, 32'h2);
    step(1);
    check_irq("R6 high active", 4'h2);
    pins[1] = 1'b0;
    step(3);
    check_irq("R6 released", 4'h0);

    // R8 rising edge on line 5 -> wire 2
    pins[5] = 1'b0;
    step(3);
    wr_reg(8'h10, 32'h20);
    wr_reg(8'h14, 32'h20);
    wr_reg(8'h0C, 32'h20);
    step(1);
    check_irq("R8 idle", 4'h0);
    pins[5] = 1'b1;
    step(2);
    check_irq("R8 not yet", 4'h0);
    step(1);
    check_irq("R8 pulse", 4'h4);
    step(1);
    check_irq("R8 one cycle", 4'h0);

    // R7 falling edge on line 6 -> wire 2
    wr_reg(8'h10, 32'h0);
    wr_reg(8'h14, 32'h40);
    wr_reg(8'h0C, 32'h40);
    step(1);
    check_irq("R7 idle", 4'h0);
    pins[6] = 1'b0;
    step(3);
    check_irq("R7 pulse", 4'h4);
    step(1);
    check_irq("R7 one cycle", 4'h0);
    pins[6] = 1'b1;
    step(3);
    check_irq("R7 rising ignored", 4'h0);
    step(1);
    check_irq("R7 rising ignored 2", 4'h0);

    // R11 lines 5 and 6 share wire 2, both level high
    wr_reg(8'h14, 32'h0);
    wr_reg(8'h10, 32'h60);
    wr_reg(8'h0C, 32'h60);
    pins[6] = 1'b0;
    step(3);
    check_irq("R11 line5", 4'h4);
    pins[5] = 1'b0;
    pins[6] = 1'b1;
    step(3);
    check_irq("R11 handover", 4'h4);
    pins[6] = 1'b0;
    step(3);
    check_irq("R11 none", 4'h0);

    // R10 unrouted lines 2 (none bit), 3 (0x80), 9 (index 7)
    wr_reg(8'h10, 32'h0);
    wr_reg(8'h0C, 32'h0000020C);
    pins[2] = 1'b0;
    pins[3] = 1'b0;
    pins[9] = 1'b0;
    step(3);
    check_irq("R10 unrouted", 4'h0);
    wr_reg(8'h28, 32'h80800380);
    step(1);
    check_irq("R10 routed to 3", 4'h8);
    wr_reg(8'h0C, 32'h0);

    // R4 skip synchroniser on line 0
    pins = 32'h0;
    step(3);
    wr_reg(8'h18, 32'h1);
    pins = 32'h3;
    rd_reg(8'h00, 32'h1, "R4 skip immediate");
    step(2);
    rd_reg(8'h00, 32'h3, "R4 synced later");
    wr_reg(8'h0C, 32'h1);
    pins[0] = 1'b0;
    step(1);
    check_irq("R4 fast irq", 4'h1);
    rd_reg(8'h18, 32'h1, "R4 skip read");

    step(2);
    done = 1'b1;
    finish_run();
  end

endmodule